// File: doc/BRIEF.md
# Digital Phase-Locked Frequency Multiplier (x16)

This block follows a slow square-wave reference and produces a clock at sixteen times the reference frequency. No oscillator is involved. The output starts as a fixed division of the fast system clock. The loop speeds it up or slows it down by putting in or taking out single output half-cycles. Those corrections come from an up/down counter of programmable modulus, which acts as the loop filter.

The reference is first brought into the clock domain. An XOR phase detector then compares it with the divided feedback. The XOR result sets the counting direction. When the counter wraps upward it emits a carry. When it wraps downward it emits a borrow. A carry puts one extra half-cycle into the output and a borrow removes one. The output is divided by sixteen, and that divided signal is the feedback.

With no corrections, the output runs at a quarter of the system clock. This gives a center reference period of 64 system clocks. A larger counter modulus gives less jitter but a narrower hold range. Deasserting the enable opens the loop.

Top module: `adpll_mult`

## Requirements
- R1: While `rst_n` is low, `clk_mul` and `fb_out` are 0.
- R2: `ref_in` passes through two synchronizing flops. The counting direction is up when the synchronized reference differs from `fb_out`, and down when they match.
- R3: The counter modulus is K = 2^(`k_sel`+1). With `k_sel`=3, K is 16. After any enabled step the count lies in 0..K-1.
- R4: An up step from K-1 wraps to 0 and produces a carry. A down step from 0 wraps to K-1 and produces a borrow. Carry and borrow are never produced in the same cycle.
- R5: While `k_en` is 0 the count holds and no carry or borrow is produced. `clk_mul` then has a period of exactly 4 clocks and `fb_out` a period of exactly 64 clocks.
- R6: With no correction pending, `clk_mul` toggles on every second clock.
- R7: Each carry adds one toggle to `clk_mul` and each borrow removes one. A pending carry and a pending borrow cancel each other.
- R8: `fb_out` is `clk_mul` divided by 16. It changes only in the cycle after a rising edge of `clk_mul`.
- R9: Let P be the reference period in clocks. With `k_en`=1 and |64-P|·K < 2P, the loop holds lock. Over 60 reference periods, the count of `fb_out` rising edges is within 1 of 60.
- R10: When the condition in R9 fails, or `k_en` is 0 and P is not 64, the loop does not lock. The count of `fb_out` rising edges over 60 reference periods differs from 60 by at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_en | input | 1 | Enables the loop-filter counter |
| k_sel | input | 3 | Modulus select, K = 2^(k_sel+1) |
| ref_in | input | 1 | Asynchronous reference square wave |
| clk_mul | output | 1 | Multiplied clock, 16 times the reference when locked |
| fb_out | output | 1 | Feedback, clk_mul divided by 16 |

## Verification
The first pattern is open loop: the enable is low and the reference runs off-center. This shows that the fixed output rate (a 4-clock output period and a 64-clock feedback period) is what remains when no corrections are applied. Directed references at the center, 6% fast and 9% slow with K=16 show that both carries and borrows steer the output. The same fast reference is then tried with K=256, which shows that the modulus sets the hold range. Seeded random periods and moduli inside the hold range then repeat the lock check. The expected lock outcome for each case is computed from the hold-range inequality.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
  // loop-filter correction pulses toward the half-cycle stage
  typedef struct packed {
    logic carry;
    logic borrow;
  } corr_t;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/adpll_rst_sync.sv
module adpll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_s = stage_q[1];
endmodule

// File: rtl/adpll_kcounter.sv
module adpll_kcounter
  import adpll_pkg::*;
#(
  parameter int KSEL_W = 3,
  localparam int KCNT_W = 1 << KSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  dir_e              dir,
  input  logic [KSEL_W-1:0] k_sel,
  output logic [KCNT_W-1:0] count,
  output corr_t             corr
);
  logic [KCNT_W:0]   kmod;
  logic [KCNT_W-1:0] kmax;
  logic [KCNT_W-1:0] cnt_q, cnt_d;
  corr_t             corr_d;

  always_comb begin
    kmod = (KCNT_W+1)'(1) << ({1'b0, k_sel} + 1'b1);
    kmax = KCNT_W'(kmod - 1'b1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    corr_d = '0;
    if (en) begin
      if (dir == DIR_UP) begin
        if (cnt_q >= kmax) begin
          cnt_d        = '0;
          corr_d.carry = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d         = kmax;
          corr_d.borrow = 1'b1;
        end else if (cnt_q > kmax) begin
          cnt_d = kmax;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign corr  = corr_d;
endmodule

// File: rtl/adpll_idstage.sv
module adpll_idstage
  import adpll_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  corr_t corr,
  output logic  out
);
  logic tick_q, out_q, cpend_q, bpend_q;
  logic tick_d, out_d, cpend_d, bpend_d;
  logic use_c, use_b;

  always_comb begin
    tick_d = ~tick_q;
    out_d  = out_q;
    use_c  = 1'b0;
    use_b  = 1'b0;
    if (tick_q) begin
      if (bpend_q) use_b = 1'b1;      // swallow the due toggle
      else         out_d = ~out_q;
    end else if (cpend_q) begin
      use_c = 1'b1;                   // insert an extra toggle
      out_d = ~out_q;
    end
    cpend_d = (cpend_q & ~use_c) | corr.carry;
    bpend_d = (bpend_q & ~use_b) | corr.borrow;
    if (cpend_d && bpend_d) begin
      cpend_d = 1'b0;
      bpend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q  <= 1'b0;
      out_q   <= 1'b0;
      cpend_q <= 1'b0;
      bpend_q <= 1'b0;
    end else begin
      tick_q  <= tick_d;
      out_q   <= out_d;
      cpend_q <= cpend_d;
      bpend_q <= bpend_d;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/adpll_divider.sv
module adpll_divider #(
  parameter int N_DIV = 16,
  localparam int DIV_W = $clog2(N_DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_clk,
  output logic div_out
);
  logic             prev_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             rise;

  always_comb begin
    rise  = in_clk & ~prev_q;
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= in_clk;
      if (rise) cnt_q <= cnt_d;
    end
  end

  assign div_out = cnt_q[DIV_W-1];
endmodule

// File: rtl/adpll_mult.sv
module adpll_mult
  import adpll_pkg::*;
#(
  parameter int N_DIV  = 16,
  parameter int KSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_en,
  input  logic [KSEL_W-1:0] k_sel,
  input  logic              ref_in,
  output logic              clk_mul,
  output logic              fb_out
);
  localparam int KCNT_W = 1 << KSEL_W;

  logic              rst_n_s;
  logic [1:0]        ref_sync_q;
  dir_e              dir;
  corr_t             corr;
  logic [KCNT_W-1:0] kcount;

  adpll_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ref_sync_q <= 2'b00;
    else          ref_sync_q <= {ref_sync_q[0], ref_in};
  end

  // XOR phase detector: disagreement counts up
  assign dir = (ref_sync_q[1] ^ fb_out) ? DIR_UP : DIR_DOWN;

  adpll_kcounter #(.KSEL_W(KSEL_W)) u_kcnt (
    .clk(clk), .rst_n(rst_n_s), .en(k_en), .dir(dir),
    .k_sel(k_sel), .count(kcount), .corr(corr)
  );

  adpll_idstage u_id (.clk(clk), .rst_n(rst_n_s), .corr(corr), .out(clk_mul));

  adpll_divider #(.N_DIV(N_DIV)) u_div (
    .clk(clk), .rst_n(rst_n_s), .in_clk(clk_mul), .div_out(fb_out)
  );
endmodule

// File: rtl/adpll_mult_chk.sv
module adpll_mult_chk #(
  parameter int KSEL_W = 3,
  localparam int KCNT_W = 1 << KSEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              k_en,
  input logic [KSEL_W-1:0] k_sel,
  input logic [KCNT_W-1:0] kcount,
  input logic              carry,
  input logic              borrow,
  input logic              clk_mul,
  input logic              fb_out
);
  logic [KCNT_W:0] top_val;
  assign top_val = ((KCNT_W+1)'(2) << k_sel) - 1'b1;

  // R3: an enabled step leaves the count within the modulus
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    k_en |=> ({1'b0, kcount} <= $past(top_val)));

  // R4: carry and borrow are exclusive
  assert_no_dual_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry && borrow));

  // R5: a disabled counter holds its value
  assert_frozen_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !k_en |=> $stable(kcount));

  // R8: the feedback moves only right after a rising output edge
  assert_fb_follows_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_out) |-> ($past(clk_mul) && !$past(clk_mul, 2)));
endmodule

bind adpll_mult adpll_mult_chk #(.KSEL_W(KSEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .k_en(k_en), .k_sel(k_sel), .kcount(kcount),
  .carry(corr.carry), .borrow(corr.borrow), .clk_mul(clk_mul), .fb_out(fb_out)
);

// File: tb/adpll_mult_test.sv
module adpll_mult_test;
  localparam int CLK_PER = 10;
  localparam int WIN     = 60;

  logic       clk = 1'b0;
  logic       rst_n, k_en, ref_in;
  logic [2:0] k_sel;
  logic       clk_mul, fb_out;
  int         ref_half = 32;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  adpll_mult uut (.clk(clk), .rst_n(rst_n), .k_en(k_en), .k_sel(k_sel),
                  .ref_in(ref_in), .clk_mul(clk_mul), .fb_out(fb_out));

  // reference generator, driven away from the active edge
  initial begin
    ref_in = 1'b0;
    forever begin
      repeat (ref_half) @(negedge clk);
      ref_in = ~ref_in;
    end
  end

  function automatic bit holds(int p, int ksel, bit en);
    int k = 2 << ksel;
    int off = (p > 64) ? p - 64 : 64 - p;
    if (!en) return (p == 64);
    return (off * k < 2 * p);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_fb(int clocks, output int rises);
    logic pf = fb_out;
    rises = 0;
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      if (fb_out && !pf) rises++;
      pf = fb_out;
    end
  endtask

  task automatic lock_case(int p, int ksel, bit en, string req);
    int r, d;
    bit exp_lock;
    k_sel = 3'(ksel);
    k_en = en;
    ref_half = p / 2;
    repeat (150 * p) @(negedge clk);
    count_fb(WIN * p, r);
    d = (r > WIN) ? r - WIN : WIN - r;
    exp_lock = holds(p, ksel, en);
    if (exp_lock) check(d <= 1, req, r, WIN);
    else          check(d >= 2, req, r, WIN);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    summary();
  end

  initial begin
    int toggles, gap, last, first_gap;
    logic pm;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    k_en  = 1'b0;
    k_sel = 3'd3;
    repeat (5) @(negedge clk);
    check(clk_mul == 1'b0, "R1 clk_mul", clk_mul, 0);
    check(fb_out == 1'b0, "R1 fb_out", fb_out, 0);
    rst_n = 1'b1;

    // R5/R6: open loop with an off-center reference
    ref_half = 30;
    repeat (200) @(negedge clk);
    toggles = 0;
    pm = clk_mul;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (clk_mul != pm) toggles++;
      pm = clk_mul;
    end
    check(toggles == 32, "R6 toggles per 64 clocks", toggles, 32);
    gap = 0; last = -1; first_gap = 0;
    pm = fb_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (fb_out && !pm) begin
        if (last >= 0) begin
          if (first_gap == 0) first_gap = i - last;
          else gap = i - last;
        end
        last = i;
      end
      pm = fb_out;
    end
    check(first_gap == 64, "R5 fb period", first_gap, 64);
    check(gap == 64, "R5 fb period again", gap, 64);
    lock_case(60, 3, 1'b0, "R10 open loop off-center");

    // directed lock cases
    lock_case(64, 3, 1'b1, "R9 center K=16");
    lock_case(60, 3, 1'b1, "R9 R7 R4 R2 fast ref K=16 (carries)");
    lock_case(70, 3, 1'b1, "R9 R7 R4 slow ref K=16 (borrows)");
    lock_case(60, 7, 1'b1, "R10 R3 fast ref K=256");
    lock_case(60, 3, 1'b1, "R9 R3 relock K=16");

    // R9: random periods and moduli inside the hold range
    for (int t = 0; t < 4; t++) begin
      int p = 60 + 2 * int'($urandom_range(0, 4));
      int ks = 2 + int'($urandom_range(0, 1));
      lock_case(p, ks, 1'b1, "R9 random");
    end
    summary();
  end
endmodule